// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Bit-Shared RAM

This block is a 4096-bit storage array reached through two independent synchronous ports, A and B. Each port has its own clock, enable, write enable, output-clear input, address, write data and registered read data. Each port's data width is set by a parameter to 1, 2, 4, 8 or 16 bits. The port's depth, and so its address width, follows from that width. The two ports may use different widths. Both see the same bits, because a word of width W at address N covers array bits N*W through N*W+W-1.

A port does nothing while its enable is inactive: nothing is written and its output keeps its value. With enable active, the port either reads or writes. A write also puts the written word on that port's output, so writes are write-first. The output-clear input zeroes only the output register and never touches the stored bits. Each of the clock, enable, write enable and clear inputs can be made active-low through its own parameter.

The array is built from two bit planes, one owned by each clock domain. The stored value is their XOR, so each plane has exactly one writer. The ports carry plain control pins with no handshake: a request is taken on every active edge on which enable is asserted, and no back-pressure exists. All storage and both output registers power up at zero.

Top module: `mixed_dpram`

## Requirements
- R1: Each port's width parameter may be 1, 2, 4, 8 or 16. Its address width is 12 minus log2(width), giving depths of 4096, 2048, 1024, 512 and 256. The total storage is 4096 bits.
- R2: Each port samples all of its inputs, and updates its output, only on the active edge of its own clock.
- R3: While a port's enable is inactive, that port writes no array bit and its output holds its previous value, whatever its write-enable, clear, address and data inputs are.
- R4: With enable and write enable active, the data-in word is stored at the addressed location. On that same edge the output takes the data-in word, unless clear is active.
- R5: With enable and clear active, the output becomes zero on that edge. The array is not changed by the clear. A write requested on the same edge is still stored, and a write on the other port is not disturbed.
- R6: With enable active and write enable inactive, the output takes the addressed contents as they stood before that edge.
- R7: A word of width W at address N occupies array bits N*W to N*W+W-1. Data bit 0 maps to array bit N*W, and each higher data bit maps to the next higher array bit.
- R8: The parameters INV_CLK_x, INV_EN_x, INV_WE_x and INV_RST_x each make the matching input of port x active-low (for the clock, falling-edge triggered) when set to 1.
- R9: When both ports write overlapping bits on the same clock edge, the overlapping bits take port A's data. Port B's non-overlapping bits are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A output clear |
| addr_a | input | 12-log2(A_W) | Port A word address |
| din_a | input | A_W | Port A write data |
| dout_a | output | A_W | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B output clear |
| addr_b | input | 12-log2(B_W) | Port B word address |
| din_b | input | B_W | Port B write data |
| dout_b | output | B_W | Port B registered read data |

## Verification
The assertions assume that each port's inputs are settled at that port's active edge. The port-A-priority rule also assumes that, when both ports write, the clocks share the same edge, so that port B's write logic sees port A's request in the same instant. The stimulus drives both ports from one clock and changes every input on the inactive edge only, so every collision is a true same-edge collision. Random traffic mixes reads, writes, clears and disabled cycles on overlapping addresses, together with sweeps that write through one width and read back through the other. Port A's write enable and port B's clear are inverted, so that the polarity options are exercised.

// File: rtl/mixed_dpram_pkg.sv
package mixed_dpram_pkg;
  localparam int unsigned ARRAY_BITS = 4096;
  localparam int unsigned BIT_IDX_W  = 12;

  function automatic int unsigned width_log2(input int unsigned w);
    int unsigned r;
    r = 0;
    while ((1 << r) < w) r++;
    return r;
  endfunction

  function automatic int unsigned addr_width(input int unsigned w);
    return BIT_IDX_W - width_log2(w);
  endfunction

  typedef struct packed {
    logic en;
    logic we;
    logic clr;
  } port_ctl_t;
endpackage

// File: rtl/mixed_dpram_ctl.sv
module mixed_dpram_ctl #(
  parameter bit INV_CLK = 1'b0,
  parameter bit INV_EN  = 1'b0,
  parameter bit INV_WE  = 1'b0,
  parameter bit INV_RST = 1'b0
) (
  input  logic                        clk_raw,
  input  logic                        en_raw,
  input  logic                        we_raw,
  input  logic                        rst_raw,
  output logic                        clk_eff,
  output mixed_dpram_pkg::port_ctl_t  ctl
);
  assign clk_eff = clk_raw ^ INV_CLK;
  assign ctl.en  = en_raw  ^ INV_EN;
  assign ctl.we  = we_raw  ^ INV_WE;
  assign ctl.clr = rst_raw ^ INV_RST;
endmodule

// File: rtl/mixed_dpram_plane.sv
module mixed_dpram_plane
  import mixed_dpram_pkg::*;
#(
  parameter int unsigned W       = 4,
  parameter int unsigned OTHER_W = 16,
  parameter bit          YIELD   = 1'b0,
  localparam int unsigned AW     = addr_width(W),
  localparam int unsigned OAW    = addr_width(OTHER_W),
  localparam int unsigned LW     = width_log2(W),
  localparam int unsigned OLW    = width_log2(OTHER_W)
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          din,
  input  logic                  other_wr,
  input  logic [OAW-1:0]        other_addr,
  input  logic [ARRAY_BITS-1:0] other_plane,
  output logic [ARRAY_BITS-1:0] plane
);
  logic [ARRAY_BITS-1:0] bits_q = '0;
  logic [BIT_IDX_W-1:0]  base;
  logic [W-1:0]          yield_bit;

  assign base = BIT_IDX_W'(addr) << LW;

  generate
    if (YIELD) begin : g_yield
      always_comb begin
        for (int j = 0; j < W; j++) begin
          yield_bit[j] = other_wr &&
            (((base + BIT_IDX_W'(j)) >> OLW) == BIT_IDX_W'(other_addr));
        end
      end
    end else begin : g_own
      assign yield_bit = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int j = 0; j < W; j++) begin
        if (!yield_bit[j])
          bits_q[base + BIT_IDX_W'(j)] <= din[j] ^ other_plane[base + BIT_IDX_W'(j)];
      end
    end
  end

  assign plane = bits_q;

  AST_IDLE_PLANE_STABLE: assert property (@(posedge clk) disable iff (1'b0)
    !wr |=> $stable(bits_q)) else $error("plane changed without write"); // R3

  AST_CLEAR_ONLY_NO_CHANGE: assert property (@(posedge clk) disable iff (wr)
    clr |=> $stable(bits_q)) else $error("clear altered storage"); // R5
endmodule

// File: rtl/mixed_dpram_out.sv
module mixed_dpram_out #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         en,
  input  logic         we,
  input  logic         clr,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rd_word,
  output logic [W-1:0] dout
);
  logic [W-1:0] q = '0;

  always_ff @(posedge clk) begin
    if (en) begin
      if (clr)      q <= '0;
      else if (we)  q <= din;
      else          q <= rd_word;
    end
  end

  assign dout = q;

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (1'b0)
    !en |=> $stable(dout)) else $error("output moved while disabled"); // R3

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (clr)
    en && we |=> dout == $past(din)) else $error("write data not echoed"); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!en)
    clr |=> dout == '0) else $error("clear did not zero output"); // R5

  AST_READ_OLD: assert property (@(posedge clk) disable iff (clr || we)
    en |=> dout == $past(rd_word)) else $error("read word mismatch"); // R6
endmodule

// File: rtl/mixed_dpram.sv
module mixed_dpram
  import mixed_dpram_pkg::*;
#(
  parameter int unsigned A_W       = 4,
  parameter int unsigned B_W       = 16,
  parameter bit          INV_CLK_A = 1'b0,
  parameter bit          INV_EN_A  = 1'b0,
  parameter bit          INV_WE_A  = 1'b0,
  parameter bit          INV_RST_A = 1'b0,
  parameter bit          INV_CLK_B = 1'b0,
  parameter bit          INV_EN_B  = 1'b0,
  parameter bit          INV_WE_B  = 1'b0,
  parameter bit          INV_RST_B = 1'b0,
  localparam int unsigned AAW      = addr_width(A_W),
  localparam int unsigned BAW      = addr_width(B_W),
  localparam int unsigned ALW      = width_log2(A_W),
  localparam int unsigned BLW      = width_log2(B_W)
) (
  input  logic           clk_a,
  input  logic           en_a,
  input  logic           we_a,
  input  logic           rst_a,
  input  logic [AAW-1:0] addr_a,
  input  logic [A_W-1:0] din_a,
  output logic [A_W-1:0] dout_a,
  input  logic           clk_b,
  input  logic           en_b,
  input  logic           we_b,
  input  logic           rst_b,
  input  logic [BAW-1:0] addr_b,
  input  logic [B_W-1:0] din_b,
  output logic [B_W-1:0] dout_b
);
  logic      ck_a, ck_b;
  port_ctl_t c_a, c_b;
  logic      wr_a, wr_b;
  logic [ARRAY_BITS-1:0] plane_a, plane_b, merged;
  logic [A_W-1:0] rd_a;
  logic [B_W-1:0] rd_b;

  mixed_dpram_ctl #(.INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
                    .INV_WE(INV_WE_A), .INV_RST(INV_RST_A)) u_ctl_a (
    .clk_raw(clk_a), .en_raw(en_a), .we_raw(we_a), .rst_raw(rst_a),
    .clk_eff(ck_a), .ctl(c_a));

  mixed_dpram_ctl #(.INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
                    .INV_WE(INV_WE_B), .INV_RST(INV_RST_B)) u_ctl_b (
    .clk_raw(clk_b), .en_raw(en_b), .we_raw(we_b), .rst_raw(rst_b),
    .clk_eff(ck_b), .ctl(c_b));

  assign wr_a = c_a.en && c_a.we;
  assign wr_b = c_b.en && c_b.we;

  mixed_dpram_plane #(.W(A_W), .OTHER_W(B_W), .YIELD(1'b0)) u_plane_a (
    .clk(ck_a), .clr(c_a.clr), .wr(wr_a), .addr(addr_a), .din(din_a),
    .other_wr(wr_b), .other_addr(addr_b), .other_plane(plane_b),
    .plane(plane_a));

  mixed_dpram_plane #(.W(B_W), .OTHER_W(A_W), .YIELD(1'b1)) u_plane_b (
    .clk(ck_b), .clr(c_b.clr), .wr(wr_b), .addr(addr_b), .din(din_b),
    .other_wr(wr_a), .other_addr(addr_a), .other_plane(plane_a),
    .plane(plane_b));

  assign merged = plane_a ^ plane_b;
  assign rd_a   = merged[(BIT_IDX_W'(addr_a) << ALW) +: A_W];
  assign rd_b   = merged[(BIT_IDX_W'(addr_b) << BLW) +: B_W];

  mixed_dpram_out #(.W(A_W)) u_out_a (
    .clk(ck_a), .en(c_a.en), .we(c_a.we), .clr(c_a.clr),
    .din(din_a), .rd_word(rd_a), .dout(dout_a));

  mixed_dpram_out #(.W(B_W)) u_out_b (
    .clk(ck_b), .en(c_b.en), .we(c_b.we), .clr(c_b.clr),
    .din(din_b), .rd_word(rd_b), .dout(dout_b));

  AST_A_WRITE_LANDS: assert property (@(posedge ck_a) disable iff (wr_b)
    wr_a |=> merged[(BIT_IDX_W'($past(addr_a)) << ALW) +: A_W] == $past(din_a))
    else $error("port A write not stored at mapped bits"); // R7
endmodule

// File: tb/tb_mixed_dpram.sv
module tb_mixed_dpram;
  localparam int unsigned AW_A = 10;
  localparam int unsigned AW_B = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            a_en = 0, a_we = 0, a_clr = 0;
  logic [AW_A-1:0] a_addr = '0;
  logic [3:0]      a_din = '0;
  logic            b_en = 0, b_we = 0, b_clr = 0;
  logic [AW_B-1:0] b_addr = '0;
  logic [15:0]     b_din = '0;
  logic [3:0]      dout_a;
  logic [15:0]     dout_b;

  mixed_dpram #(.A_W(4), .B_W(16), .INV_WE_A(1'b1), .INV_RST_B(1'b1)) dut (
    .clk_a(clk), .en_a(a_en), .we_a(~a_we), .rst_a(a_clr),
    .addr_a(a_addr), .din_a(a_din), .dout_a(dout_a),
    .clk_b(clk), .en_b(b_en), .we_b(b_we), .rst_b(~b_clr),
    .addr_b(b_addr), .din_b(b_din), .dout_b(dout_b));

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [4095:0] ref_bits = '0;
  logic [3:0]    exp_a = '0;
  logic [15:0]   exp_b = '0;
  string         tag_a = "R1 R2 reset-state";
  string         tag_b = "R1 R2 reset-state";

  always @(posedge clk) begin
    logic [4095:0] old;
    int ba, bb;
    bit coll;
    old  = ref_bits;
    ba   = int'(a_addr) * 4;
    bb   = int'(b_addr) * 16;
    coll = a_en && a_we && b_en && b_we && ((ba / 16) == int'(b_addr));
    if (b_en && b_we) for (int j = 0; j < 16; j++) ref_bits[bb + j] = b_din[j];
    if (a_en && a_we) for (int j = 0; j < 4; j++)  ref_bits[ba + j] = a_din[j];
    if (a_en) begin
      if (a_clr)     begin exp_a = '0;    tag_a = "R5 R8 clear"; end
      else if (a_we) begin exp_a = a_din; tag_a = coll ? "R4 R8 R9 write" : "R4 R8 write"; end
      else begin
        for (int j = 0; j < 4; j++) exp_a[j] = old[ba + j];
        tag_a = "R6 R7 read";
      end
    end else tag_a = "R3 hold";
    if (b_en) begin
      if (b_clr)     begin exp_b = '0;    tag_b = "R5 R8 clear"; end
      else if (b_we) begin exp_b = b_din; tag_b = coll ? "R4 R9 write" : "R4 write"; end
      else begin
        for (int j = 0; j < 16; j++) exp_b[j] = old[bb + j];
        tag_b = "R6 R7 R9 read";
      end
    end else tag_b = "R3 hold";
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (dout_a !== exp_a) begin
        misses++;
        $display("FAIL %s port A: got %h expected %h", tag_a, dout_a, exp_a);
      end
      vectors++;
      if (dout_b !== exp_b) begin
        misses++;
        $display("FAIL %s port B: got %h expected %h", tag_b, dout_b, exp_b);
      end
    end
  end

  task automatic idle_all();
    a_en = 0; a_we = 0; a_clr = 0;
    b_en = 0; b_we = 0; b_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: fill through the wide port, read back through the narrow one
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); idle_all();
      b_en = 1; b_we = 1; b_addr = AW_B'(i); b_din = 16'(i * 16'h9E37 + 16'h1234);
    end
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk); idle_all();
      a_en = 1; a_addr = AW_A'(i);
    end
    // R7: fill through the narrow port, read back through the wide one
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk); idle_all();
      a_en = 1; a_we = 1; a_addr = AW_A'(i); a_din = 4'(i * 7 + 3);
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); idle_all();
      b_en = 1; b_addr = AW_B'(i);
    end
    // R5: clear together with a write, then read back the written word
    @(negedge clk); idle_all();
    a_en = 1; a_we = 1; a_clr = 1; a_addr = 10'd5; a_din = 4'hA;
    @(negedge clk); idle_all(); a_en = 1; a_addr = 10'd5;
    // R3: disabled write request, then read that location
    @(negedge clk); idle_all(); a_we = 1; a_clr = 1; a_addr = 10'd9; a_din = 4'h0;
    b_we = 1; b_addr = 8'd2; b_din = 16'hFFFF;
    @(negedge clk); idle_all(); a_en = 1; a_addr = 10'd9; b_en = 1; b_addr = 8'd2;
    // R9: same-edge overlapping writes, then read
    @(negedge clk); idle_all();
    a_en = 1; a_we = 1; a_addr = 10'd17; a_din = 4'h5;
    b_en = 1; b_we = 1; b_addr = 8'd4;  b_din = 16'hC3C3;
    @(negedge clk); idle_all(); b_en = 1; b_addr = 8'd4;
    // mixed random traffic on a narrow window so collisions occur
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      a_en = 1'($urandom_range(0, 3) != 0); a_we = 1'($urandom);
      a_clr = 1'($urandom_range(0, 7) == 0);
      a_addr = AW_A'($urandom_range(0, 31)); a_din = 4'($urandom);
      b_en = 1'($urandom_range(0, 3) != 0); b_we = 1'($urandom);
      b_clr = 1'($urandom_range(0, 7) == 0);
      b_addr = AW_B'($urandom_range(0, 7)); b_din = 16'($urandom);
    end
    @(negedge clk); idle_all();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule